// File: doc/BRIEF.md
# Calendar Shadow Register Synchronizer

This block sits between a calendar that advances in a slow real-time clock domain and a register reader on a much faster bus clock. It keeps a bus-side copy of the calendar's subseconds, time and date words. On each rising edge of the slow clock it refreshes that copy, and all three words are captured together in a single bus cycle. Each refresh raises a sync-ready flag. Software can poll this flag to learn that the copy is fresh, and it clears the flag with a clear strobe.

While a low-power mode input is high, refreshes are suppressed. The first slow-clock rising edge after the mode input falls refreshes the copy again. A bypass control bit makes reads return the live calendar words instead of the shadow copy. The bus clock must run at least seven times faster than the slow clock. Calendar counting and the bus protocol belong to neighbouring blocks.

Top module: `cal_shadow_sync`

## Requirements
- R1: When low-power mode is off, each rising edge of `rtc_tick` loads `live_ssec`, `live_time` and `live_date` into the shadow registers in the same bus cycle. The load happens on the third rising `clk` edge after the tick rise is first sampled.
- R2: Each load sets `sync_rdy` on the edge where the load takes place.
- R3: While `lp_mode` is 1, no load takes place: the shadow words keep their values and `sync_rdy` does not rise.
- R4: After `lp_mode` returns to 0, the next rising edge of `rtc_tick` reloads the shadow words, which is well within 4 slow-clock periods.
- R5: With bypass off, `rd_en` returns a value on `rd_data` with `rd_valid` high one cycle later. The address selects the word: 0 gives subseconds, 1 gives time and 2 gives date, each read from the shadow registers. Address 3 gives status, with bit 0 = `sync_rdy`, bit 1 = bypass and all other bits 0.
- R6: With bypass on, reads of addresses 0 to 2 return the live input words present in the `rd_en` cycle.
- R7: Reset (`rst_n` low at a `clk` edge) clears the shadow words, the bypass bit, `sync_rdy` and `rd_valid`.
- R8: A `flag_clr` pulse clears `sync_rdy`. If a load occurs in the same cycle, the load wins and the flag stays 1.
- R9: After reset, `sync_rdy` stays 0 until the first load.
- R10: A `ctl_we` pulse writes `ctl_byp` into the bypass bit, and the bit is visible on the `bypass` output on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rtc_tick | input | 1 | Slow real-time clock, sampled as data |
| lp_mode | input | 1 | Low-power mode active; suppresses refresh |
| live_ssec | input | SSW | Live subseconds word |
| live_time | input | TW | Live time word |
| live_date | input | DW | Live date word |
| ctl_we | input | 1 | Write strobe for the bypass bit |
| ctl_byp | input | 1 | Bypass value to write |
| flag_clr | input | 1 | Clear strobe for sync_rdy |
| rd_en | input | 1 | Read request |
| rd_addr | input | 2 | Read word select |
| rd_data | output | RDW | Read data |
| rd_valid | output | 1 | Read data valid |
| sync_rdy | output | 1 | Shadow refreshed since last clear |
| bypass | output | 1 | Current bypass setting |

## Verification
The refresh path is tested with three kinds of tick streams:
- Normal ticks with calendar words that change between ticks. These show that the copy tracks each tick, as opposed to loading once or loading a single word.
- Ticks during low-power mode. These separate a gated copy from a copy that ignores the mode input.
- Ticks aligned so that a load and a clear land in the same cycle. These expose the wrong priority between the two.

Reads are issued with bypass both off and on while the live words differ from the shadow copy. This distinguishes the two read sources.

// File: rtl/cal_shadow_pkg.sv
// Package: shared read-address encoding and status bit positions for the
// calendar shadow synchronizer. Assumes a 2-bit read address.
package cal_shadow_pkg;

    typedef enum logic [1:0] {
        RA_SSEC = 2'd0,
        RA_TIME = 2'd1,
        RA_DATE = 2'd2,
        RA_STAT = 2'd3
    } rd_sel_e;

    localparam int STAT_RDY_BIT = 0;
    localparam int STAT_BYP_BIT = 1;

endpackage

// File: rtl/tick_edge_sync.sv
// Module: brings the slow tick into the bus domain through a STAGES-deep
// flop chain and emits a one-cycle pulse on its rising edge.
// Assumes the bus clock is at least 7x the tick rate, so every tick high and
// low phase spans several bus cycles.
module tick_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic rise_pulse
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Synchronizer chain: first stage samples the asynchronous tick.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= tick_in;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Further synchronizer stages.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    // History flop for the edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    // Rising-edge pulse on the synchronized tick.
    always_comb rise_pulse = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/shadow_bank.sv
// Module: holds the three shadow calendar words and loads them together
// when load is high. Assumes the live words are stable around the tick edge.
module shadow_bank #(
    parameter int SSW = 16,
    parameter int TW  = 32,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [SSW-1:0] in_ssec,
    input  logic [TW-1:0]  in_time,
    input  logic [DW-1:0]  in_date,
    output logic [SSW-1:0] shd_ssec,
    output logic [TW-1:0]  shd_time,
    output logic [DW-1:0]  shd_date
);
    // Coherent capture of all three words in one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_ssec <= '0;
            shd_time <= '0;
            shd_date <= '0;
        end else if (load) begin
            shd_ssec <= in_ssec;
            shd_time <= in_time;
            shd_date <= in_date;
        end
    end

endmodule

// File: rtl/ready_flag.sv
// Module: sync-ready flag. It is set by a load and cleared by a clear strobe,
// and a load in the same cycle as a clear wins. It resets to 0.
module ready_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Set takes priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

endmodule

// File: rtl/read_port.sv
// Module: the bypass control bit and a registered read mux. The mux selects
// either the shadow words or the live words, or the status word.
// Assumes every word width is no wider than RDW.
module read_port
    import cal_shadow_pkg::*;
#(
    parameter int SSW = 16,
    parameter int TW  = 32,
    parameter int DW  = 32,
    parameter int RDW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctl_we,
    input  logic           ctl_byp,
    input  logic           rd_en,
    input  logic [1:0]     rd_addr,
    input  logic           rdy,
    input  logic [SSW-1:0] shd_ssec,
    input  logic [TW-1:0]  shd_time,
    input  logic [DW-1:0]  shd_date,
    input  logic [SSW-1:0] live_ssec,
    input  logic [TW-1:0]  live_time,
    input  logic [DW-1:0]  live_date,
    output logic           byp_o,
    output logic [RDW-1:0] rd_data,
    output logic           rd_valid
);
    logic [RDW-1:0] word_ssec, word_time, word_date, word_stat, sel_word;

    // Bypass control bit, written by the control strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      byp_o <= 1'b0;
        else if (ctl_we) byp_o <= ctl_byp;
    end

    // Source select, zero-extended to the read width.
    always_comb begin
        word_ssec = '0;
        word_time = '0;
        word_date = '0;
        word_stat = '0;
        word_ssec[SSW-1:0] = byp_o ? live_ssec : shd_ssec;
        word_time[TW-1:0]  = byp_o ? live_time : shd_time;
        word_date[DW-1:0]  = byp_o ? live_date : shd_date;
        word_stat[STAT_RDY_BIT] = rdy;
        word_stat[STAT_BYP_BIT] = byp_o;
    end

    // Address decode.
    always_comb begin
        unique case (rd_sel_e'(rd_addr))
            RA_SSEC: sel_word = word_ssec;
            RA_TIME: sel_word = word_time;
            RA_DATE: sel_word = word_date;
            default: sel_word = word_stat;
        endcase
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= sel_word;
        end
    end

endmodule

// File: rtl/cal_shadow_sync.sv
// Module (top): calendar shadow synchronizer. A rising edge on the slow tick,
// once synchronized, loads the shadow words and sets sync_rdy unless
// low-power mode is on. Assumes the bus clock is at least 7x the tick rate
// and that the live words are stable for several bus cycles after a tick
// rise.
module cal_shadow_sync #(
    parameter int SSW         = 16,
    parameter int TW          = 32,
    parameter int DW          = 32,
    parameter int RDW         = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rtc_tick,
    input  logic           lp_mode,
    input  logic [SSW-1:0] live_ssec,
    input  logic [TW-1:0]  live_time,
    input  logic [DW-1:0]  live_date,
    input  logic           ctl_we,
    input  logic           ctl_byp,
    input  logic           flag_clr,
    input  logic           rd_en,
    input  logic [1:0]     rd_addr,
    output logic [RDW-1:0] rd_data,
    output logic           rd_valid,
    output logic           sync_rdy,
    output logic           bypass
);
    logic           tick_rise;
    logic           copy_en;
    logic [SSW-1:0] shd_ssec;
    logic [TW-1:0]  shd_time;
    logic [DW-1:0]  shd_date;

    tick_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_in    (rtc_tick),
        .rise_pulse (tick_rise)
    );

    // A refresh is allowed only outside low-power mode.
    always_comb copy_en = tick_rise & ~lp_mode;

    shadow_bank #(.SSW(SSW), .TW(TW), .DW(DW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (copy_en),
        .in_ssec  (live_ssec),
        .in_time  (live_time),
        .in_date  (live_date),
        .shd_ssec (shd_ssec),
        .shd_time (shd_time),
        .shd_date (shd_date)
    );

    ready_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (copy_en),
        .clr_i  (flag_clr),
        .flag_o (sync_rdy)
    );

    read_port #(.SSW(SSW), .TW(TW), .DW(DW), .RDW(RDW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_byp   (ctl_byp),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rdy       (sync_rdy),
        .shd_ssec  (shd_ssec),
        .shd_time  (shd_time),
        .shd_date  (shd_date),
        .live_ssec (live_ssec),
        .live_time (live_time),
        .live_date (live_date),
        .byp_o     (bypass),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

endmodule

// File: rtl/cal_shadow_sync_chk.sv
// Checker: temporal properties of the shadow synchronizer, attached to the
// top module with bind.
module cal_shadow_sync_chk #(
    parameter int TW  = 32,
    parameter int RDW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           lp_mode,
    input logic           flag_clr,
    input logic           copy_en,
    input logic           sync_rdy,
    input logic           bypass,
    input logic           rd_en,
    input logic [1:0]     rd_addr,
    input logic [RDW-1:0] rd_data,
    input logic           rd_valid,
    input logic [TW-1:0]  live_time,
    input logic [TW-1:0]  shd_time
);
    p_copy_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
        copy_en |=> shd_time == $past(live_time));

    p_copy_sets_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        copy_en |=> sync_rdy);

    p_lp_holds_shadow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lp_mode |=> $stable(shd_time));

    p_lp_no_rdy_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lp_mode && !sync_rdy |=> !sync_rdy);

    p_read_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_bypass_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && bypass && rd_addr == 2'd1 |=> rd_data[TW-1:0] == $past(live_time));

    p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !copy_en |=> !sync_rdy);

    p_rdy_rise_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_rdy) |-> $past(copy_en));

endmodule

bind cal_shadow_sync cal_shadow_sync_chk #(.TW(TW), .RDW(RDW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lp_mode   (lp_mode),
    .flag_clr  (flag_clr),
    .copy_en   (copy_en),
    .sync_rdy  (sync_rdy),
    .bypass    (bypass),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .live_time (live_time),
    .shd_time  (shd_time)
);

// File: tb/tb_cal_shadow_sync.sv
// Scoreboard bench: read tasks queue expected words, and a monitor pops them
// on each valid response.
module tb_cal_shadow_sync;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rtc_tick = 1'b0;
    logic        lp_mode = 1'b0;
    logic [15:0] live_ssec = '0;
    logic [31:0] live_time = '0;
    logic [31:0] live_date = '0;
    logic        ctl_we = 1'b0, ctl_byp = 1'b0, flag_clr = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_valid, sync_rdy, bypass;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 0;

    cal_shadow_sync dut (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .lp_mode(lp_mode),
        .live_ssec(live_ssec), .live_time(live_time), .live_date(live_date),
        .ctl_we(ctl_we), .ctl_byp(ctl_byp), .flag_clr(flag_clr),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_valid(rd_valid), .sync_rdy(sync_rdy), .bypass(bypass)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected word for every valid read response.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) check("R5 unexpected response", 32'h1, 32'h0);
            else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    // One slow-clock period: 4 bus cycles high and 4 low (ratio of 8).
    task automatic tick();
        @(negedge clk); rtc_tick = 1'b1;
        repeat (4) @(negedge clk);
        rtc_tick = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_live(input logic [15:0] s, input logic [31:0] t, input logic [31:0] d);
        @(negedge clk);
        live_ssec = s; live_time = t; live_date = d;
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 / R9: reset state
        check("R7 sync_rdy after reset", {31'b0, sync_rdy}, 32'h0);
        check("R7 bypass after reset", {31'b0, bypass}, 32'h0);
        check("R7 rd_valid after reset", {31'b0, rd_valid}, 32'h0);
        rd(2'd0, 32'h0, "R7 shadow ssec reset");
        rd(2'd1, 32'h0, "R7 shadow time reset");
        rd(2'd2, 32'h0, "R7 shadow date reset");
        repeat (20) @(negedge clk);
        check("R9 sync_rdy before first load", {31'b0, sync_rdy}, 32'h0);

        // R1 / R2: first refresh
        set_live(16'h1234, 32'h0012_3456, 32'h0024_0615);
        @(negedge clk); rtc_tick = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 no load before third edge", {31'b0, sync_rdy}, 32'h0);
        @(negedge clk);
        check("R2 sync_rdy set on load edge", {31'b0, sync_rdy}, 32'h1);
        repeat (3) @(negedge clk); rtc_tick = 1'b0;
        repeat (4) @(negedge clk);
        set_live(16'hAAAA, 32'h0012_3457, 32'h0024_0616);
        rd(2'd0, 32'h0000_1234, "R1 shadow ssec");
        rd(2'd1, 32'h0012_3456, "R5 shadow time, not live");
        rd(2'd2, 32'h0024_0615, "R1 shadow date");
        rd(2'd3, 32'h0000_0001, "R5 status word");

        // R1: a second tick tracks the new words
        tick();
        rd(2'd1, 32'h0012_3457, "R1 second tick time");
        rd(2'd0, 32'h0000_AAAA, "R1 second tick ssec");

        // R8: a plain clear
        pulse_clr();
        @(negedge clk);
        check("R8 clear drops sync_rdy", {31'b0, sync_rdy}, 32'h0);

        // R3: low-power mode stalls the refresh
        @(negedge clk); lp_mode = 1'b1;
        set_live(16'h5555, 32'h0099_0000, 32'h0099_1111);
        tick(); tick();
        check("R3 no sync_rdy in low power", {31'b0, sync_rdy}, 32'h0);
        rd(2'd1, 32'h0012_3457, "R3 shadow time held");
        rd(2'd2, 32'h0024_0616, "R3 shadow date held");

        // R4: wakeup, next tick refreshes
        @(negedge clk); lp_mode = 1'b0;
        tick();
        check("R4 sync_rdy after wakeup", {31'b0, sync_rdy}, 32'h1);
        rd(2'd1, 32'h0099_0000, "R4 time refreshed after wakeup");
        rd(2'd0, 32'h0000_5555, "R4 ssec refreshed after wakeup");

        // R8: clear collides with load, load wins
        pulse_clr();
        set_live(16'h0101, 32'h0011_2233, 32'h0044_5566);
        @(negedge clk); rtc_tick = 1'b1;
        @(negedge clk);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check("R8 load wins over same-cycle clear", {31'b0, sync_rdy}, 32'h1);
        repeat (2) @(negedge clk); rtc_tick = 1'b0;
        repeat (4) @(negedge clk);

        // R10 / R6: bypass returns live words
        set_live(16'h7777, 32'h00AB_CDEF, 32'h0013_0101);
        @(negedge clk); ctl_we = 1'b1; ctl_byp = 1'b1;
        @(negedge clk); ctl_we = 1'b0;
        check("R10 bypass bit written", {31'b0, bypass}, 32'h1);
        rd(2'd1, 32'h00AB_CDEF, "R6 bypass time is live");
        rd(2'd2, 32'h0013_0101, "R6 bypass date is live");
        rd(2'd0, 32'h0000_7777, "R6 bypass ssec is live");
        rd(2'd3, 32'h0000_0003, "R5 status with bypass");

        // R10 / R5: bypass off returns the shadow copy again
        @(negedge clk); ctl_we = 1'b1; ctl_byp = 1'b0;
        @(negedge clk); ctl_we = 1'b0;
        rd(2'd1, 32'h0011_2233, "R5 shadow after bypass off");
        rd(2'd2, 32'h0044_5566, "R5 shadow date after bypass off");

        repeat (4) @(negedge clk);
        check("R5 no pending reads", exp_q.size(), 32'h0);
        finish_run();
    end

endmodule